// File: doc/BRIEF.md
# DMA Channel Run-Control and Status Register

This block is the run-control and status register of one descriptor-driven DMA channel. Software changes it with a single 32-bit little-endian write. The upper half-word of that write is a per-bit enable mask, and the lower half-word holds the new values. Only the bits whose enable is 1 change, so a driver can set or clear one control bit without first reading the register back. Reading the register returns the 16-bit status word in the low half and zeros in the high half.

The register holds four control bits for the channel engine: run, pause, flush and wake. It also holds a sticky error flag. Three fields are shown live: the engine's active and branch-taken indications, and an 8-bit device status from the peripheral. Two handshakes are built on the masked write. A stop clears run and flush, and software then polls until the engine drops active. A reset clears run, pause, flush, wake and the error flag in one write.

Top module: `dma_ctl_reg`

## Requirements
- R1: After reset, run_o, pause_o, flush_req_o and wake_o are 0. The read value is 0 when the engine and device inputs are 0.
- R2: On a write, status bit 15 (run) and bit 14 (pause) take the value bit when their mask bit (31 or 30) is 1. Otherwise they keep their value. run_o and pause_o follow these bits from the cycle after the write.
- R3: ctl_rd_data[31:16] always reads 0. ctl_rd_data[15:0] is the status word, and bit 9 always reads 0.
- R4: Bit 10 mirrors eng_active_i, bit 8 mirrors eng_bt_i and bits 7:0 mirror dev_status_i. Writes to these positions have no effect, whatever their mask.
- R5: Bit 11 (dead) is set by eng_dead_i and stays set afterwards. A write with mask bit 27 = 1 and value bit 11 = 0 clears it. A written 1 has no effect. A set from the engine wins over a clear in the same cycle.
- R6: A write of 1 to bit 13 (flush, mask bit 29) sets it, and flush_req_o follows it. The bit stays set until flush_done_i is seen or a 0 is written to it.
- R7: A write of 1 to bit 12 (wake, mask bit 28) raises wake_o and bit 12 for exactly one cycle. Both then clear without further action.
- R8: A stop write (mask bits 31 and 29 = 1, value bits 15 and 13 = 0) clears run and flush in the next cycle. Once the engine has drained, bits 13 and 10 both read 0.
- R9: A reset write (mask bits 31:26 = 1, value bits 15:10 = 0) leaves bits 15:11 reading 0 in the next cycle, provided eng_dead_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr_en | input | 1 | Register write strobe |
| ctl_wr_data | input | 32 | Write word: [31:16] bit-enable mask, [15:0] values |
| ctl_rd_data | output | 32 | Read word: zeros above the status word |
| eng_active_i | input | 1 | Engine is processing descriptors |
| eng_dead_i | input | 1 | Engine hit a fatal error (pulse or level) |
| eng_bt_i | input | 1 | Last descriptor took its branch |
| dev_status_i | input | 8 | Device status shown in the low byte |
| flush_done_i | input | 1 | Engine finished the requested flush |
| run_o | output | 1 | Channel run enable |
| pause_o | output | 1 | Channel pause request |
| flush_req_o | output | 1 | Flush request to the engine |
| wake_o | output | 1 | One-cycle wake pulse to the engine |

## Verification
The bench sweeps every prior value, mask and value of the run and pause pair. A design that ignored the mask, or treated a mask of 0 as a write of 0, would corrupt the neighbouring bit. The same writes also set mask and value bits over the engine-owned fields, so a design that latched them would show stray 1s. The bench also covers these cases:
- Error flag: a same-cycle engine error and software clear, where a design with the wrong priority would lose the error.
- Wake: a design that held wake would show a two-cycle pulse.
- Stop handshake: a stop followed by polling against a delayed engine model, where a design that left flush set would never reach idle.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned HALF_W  = WORD_W / 2;
    localparam int unsigned DEV_W   = 8;
    // status word bit positions (software depends on them)
    localparam int unsigned P_RUN    = 15;
    localparam int unsigned P_PAUSE  = 14;
    localparam int unsigned P_FLUSH  = 13;
    localparam int unsigned P_WAKE   = 12;
    localparam int unsigned P_DEAD   = 11;
    localparam int unsigned P_ACTIVE = 10;
    localparam int unsigned P_BT     = 8;
    localparam int unsigned SOFT_N   = 5;

    // held control bits; packed so bit 0 is run, bit 4 is dead
    typedef struct packed {
        logic dead;
        logic wake;
        logic flush;
        logic pause;
        logic run;
    } ctl_state_t;
endpackage

// File: rtl/dma_ctl_merge.sv
module dma_ctl_merge #(
    parameter int unsigned N = 5
) (
    input  logic         en,
    input  logic [N-1:0] mask,
    input  logic [N-1:0] val,
    input  logic [N-1:0] cur,
    output logic [N-1:0] hit,
    output logic [N-1:0] nxt
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        assign hit[i] = en & mask[i];
        assign nxt[i] = hit[i] ? val[i] : cur[i];
    end
endmodule

// File: rtl/dma_ctl_pack.sv
module dma_ctl_pack
    import dma_ctl_pkg::*;
#(
    parameter int unsigned DW = DEV_W
) (
    input  ctl_state_t        st,
    input  logic              active,
    input  logic              bt,
    input  logic [DW-1:0]     dev,
    output logic [HALF_W-1:0] word
);
    always_comb begin
        word           = '0;
        word[P_RUN]    = st.run;
        word[P_PAUSE]  = st.pause;
        word[P_FLUSH]  = st.flush;
        word[P_WAKE]   = st.wake;
        word[P_DEAD]   = st.dead;
        word[P_ACTIVE] = active;
        word[P_BT]     = bt;
        word[DW-1:0]   = dev;
    end
endmodule

// File: rtl/dma_ctl_reg.sv
module dma_ctl_reg
    import dma_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr_en,
    input  logic [WORD_W-1:0] ctl_wr_data,
    output logic [WORD_W-1:0] ctl_rd_data,
    input  logic              eng_active_i,
    input  logic              eng_dead_i,
    input  logic              eng_bt_i,
    input  logic [DEV_W-1:0]  dev_status_i,
    input  logic              flush_done_i,
    output logic              run_o,
    output logic              pause_o,
    output logic              flush_req_o,
    output logic              wake_o
);
    ctl_state_t st_d, st_q;

    logic [HALF_W-1:0] wmask, wval, word;
    logic [SOFT_N-1:0] s_mask, s_val, s_hit, s_nxt;

    assign wmask = ctl_wr_data[WORD_W-1:HALF_W];
    assign wval  = ctl_wr_data[HALF_W-1:0];

    // gather the software-held positions into soft-bit order (run = 0)
    assign s_mask = {wmask[P_DEAD], wmask[P_WAKE], wmask[P_FLUSH],
                     wmask[P_PAUSE], wmask[P_RUN]};
    assign s_val  = {wval[P_DEAD], wval[P_WAKE], wval[P_FLUSH],
                     wval[P_PAUSE], wval[P_RUN]};

    logic unused_wr_bits;
    assign unused_wr_bits = ^{wmask[P_ACTIVE:0], wval[P_ACTIVE:0]};

    dma_ctl_merge #(.N(SOFT_N)) merge_i (
        .en   (ctl_wr_en),
        .mask (s_mask),
        .val  (s_val),
        .cur  (st_q),
        .hit  (s_hit),
        .nxt  (s_nxt)
    );

    always_comb begin
        st_d       = st_q;
        st_d.run   = s_nxt[0];
        st_d.pause = s_nxt[1];
        // a write decides flush; otherwise the engine's done clears it
        st_d.flush = s_hit[2] ? s_nxt[2] : (st_q.flush & ~flush_done_i);
        // wake lives one cycle
        st_d.wake  = s_hit[3] & s_nxt[3];
        // dead: engine sets, software can only clear, set wins
        st_d.dead  = eng_dead_i | (st_q.dead & ~(s_hit[4] & ~s_val[4]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    dma_ctl_pack #(.DW(DEV_W)) pack_i (
        .st     (st_q),
        .active (eng_active_i),
        .bt     (eng_bt_i),
        .dev    (dev_status_i),
        .word   (word)
    );

    assign ctl_rd_data = {{HALF_W{1'b0}}, word};
    assign run_o       = st_q.run;
    assign pause_o     = st_q.pause;
    assign flush_req_o = st_q.flush;
    assign wake_o      = st_q.wake;
endmodule

// File: rtl/dma_ctl_reg_chk.sv
module dma_ctl_reg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ctl_wr_en,
    input logic [31:0] ctl_wr_data,
    input logic [31:0] ctl_rd_data,
    input logic        eng_active_i,
    input logic        eng_dead_i,
    input logic        eng_bt_i,
    input logic [7:0]  dev_status_i,
    input logic        flush_done_i,
    input logic        run_o,
    input logic        flush_req_o,
    input logic        wake_o
);
    a_r2_run_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_wr_en && ctl_wr_data[31]) |=> run_o == $past(run_o));
    a_r2_run_load: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr_en && ctl_wr_data[31]) |=> run_o == $past(ctl_wr_data[15]));
    a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rd_data[31:16] == 16'h0 && !ctl_rd_data[9]);
    a_r4_live_fields: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rd_data[10] == eng_active_i && ctl_rd_data[8] == eng_bt_i
        && ctl_rd_data[7:0] == dev_status_i);
    a_r5_dead_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        eng_dead_i |=> ctl_rd_data[11]);
    a_r6_flush_done: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req_o && flush_done_i && !(ctl_wr_en && ctl_wr_data[29]))
        |=> !flush_req_o);
    a_r7_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_o && !(ctl_wr_en && ctl_wr_data[28] && ctl_wr_data[12]))
        |=> !wake_o);
    a_r8_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr_en && ctl_wr_data[31] && ctl_wr_data[29]
         && !ctl_wr_data[15] && !ctl_wr_data[13]) |=> !run_o && !flush_req_o);
    a_r9_reset_write: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr_en && ctl_wr_data[31:26] == 6'h3F && ctl_wr_data[15:10] == 6'h0
         && !eng_dead_i) |=> ctl_rd_data[15:11] == 5'h0);
endmodule

bind dma_ctl_reg dma_ctl_reg_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl_wr_en    (ctl_wr_en),
    .ctl_wr_data  (ctl_wr_data),
    .ctl_rd_data  (ctl_rd_data),
    .eng_active_i (eng_active_i),
    .eng_dead_i   (eng_dead_i),
    .eng_bt_i     (eng_bt_i),
    .dev_status_i (dev_status_i),
    .flush_done_i (flush_done_i),
    .run_o        (run_o),
    .flush_req_o  (flush_req_o),
    .wake_o       (wake_o)
);

// File: tb/dma_ctl_reg_tb_top.sv
`timescale 1ns/1ps
module dma_ctl_reg_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr_en = 1'b0;
    logic [31:0] ctl_wr_data = '0;
    logic [31:0] ctl_rd_data;
    logic        eng_active_i;
    logic        tb_active = 1'b0;
    logic        use_resp = 1'b0;
    logic        eng_dead_i = 1'b0;
    logic        eng_bt_i = 1'b0;
    logic [7:0]  dev_status_i = '0;
    logic        flush_done_i = 1'b0;
    logic        run_o, pause_o, flush_req_o, wake_o;
    logic [2:0]  resp_pipe = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    // engine model: active follows run after three cycles
    always @(posedge clk) resp_pipe <= {resp_pipe[1:0], run_o};
    assign eng_active_i = use_resp ? resp_pipe[2] : tb_active;

    dma_ctl_reg dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl_wr_en    (ctl_wr_en),
        .ctl_wr_data  (ctl_wr_data),
        .ctl_rd_data  (ctl_rd_data),
        .eng_active_i (eng_active_i),
        .eng_dead_i   (eng_dead_i),
        .eng_bt_i     (eng_bt_i),
        .dev_status_i (dev_status_i),
        .flush_done_i (flush_done_i),
        .run_o        (run_o),
        .pause_o      (pause_o),
        .flush_req_o  (flush_req_o),
        .wake_o       (wake_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one write; returns at the next falling edge, after it took effect
    task automatic wr(input logic [15:0] m, input logic [15:0] v);
        @(negedge clk);
        ctl_wr_en   = 1'b1;
        ctl_wr_data = {m, v};
        @(negedge clk);
        ctl_wr_en   = 1'b0;
        ctl_wr_data = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 8);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rd", ctl_rd_data, 32'h0);
        chk("R1 outs", {28'h0, run_o, pause_o, flush_req_o, wake_o}, 32'h0);

        // R2 + R4: every prior, mask, value of run/pause; engine fields written too
        for (int p = 0; p < 4; p++) begin
            for (int m = 0; m < 4; m++) begin
                for (int v = 0; v < 4; v++) begin
                    logic [1:0] exp2;
                    wr(16'hC000, 16'(p) << 14);
                    wr((16'(m) << 14) | 16'h05FF, (16'(v) << 14) | 16'h05FF);
                    exp2 = (2'(p) & ~2'(m)) | (2'(v) & 2'(m));
                    chk("R2 bits15:14", {30'h0, ctl_rd_data[15:14]}, {30'h0, exp2});
                    chk("R2 pins", {30'h0, run_o, pause_o}, {30'h0, exp2});
                    chk("R4 written engine fields", {16'h0, ctl_rd_data[15:0] & 16'h05FF}, 32'h0);
                end
            end
        end
        wr(16'hC000, 16'h0000);

        // R3 + R4: live field sweep
        for (int d = 0; d < 256; d++) begin
            @(negedge clk);
            dev_status_i = 8'(d);
            tb_active    = d[0];
            eng_bt_i     = d[1];
            #1;
            chk("R4 live", ctl_rd_data,
                {16'h0, 5'h0, d[0], 1'b0, d[1], 8'(d)});
            chk("R3 upper/bit9", {16'h0, ctl_rd_data[31:16]} | {31'h0, ctl_rd_data[9]}, 32'h0);
        end
        @(negedge clk);
        dev_status_i = '0; tb_active = 1'b0; eng_bt_i = 1'b0;

        // R5 dead flag
        @(negedge clk); eng_dead_i = 1'b1;
        @(negedge clk); eng_dead_i = 1'b0;
        chk("R5 set", {31'h0, ctl_rd_data[11]}, 32'h1);
        repeat (3) @(negedge clk);
        chk("R5 sticky", {31'h0, ctl_rd_data[11]}, 32'h1);
        wr(16'h0800, 16'h0800);
        chk("R5 write1 ignored", {31'h0, ctl_rd_data[11]}, 32'h1);
        wr(16'h0000, 16'h0000);
        chk("R5 unmasked ignored", {31'h0, ctl_rd_data[11]}, 32'h1);
        @(negedge clk);
        ctl_wr_en = 1'b1; ctl_wr_data = {16'h0800, 16'h0000}; eng_dead_i = 1'b1;
        @(negedge clk);
        ctl_wr_en = 1'b0; ctl_wr_data = '0; eng_dead_i = 1'b0;
        chk("R5 set wins", {31'h0, ctl_rd_data[11]}, 32'h1);
        wr(16'h0800, 16'h0000);
        chk("R5 clear", {31'h0, ctl_rd_data[11]}, 32'h0);

        // R6 flush
        wr(16'h2000, 16'h2000);
        chk("R6 set", {30'h0, flush_req_o, ctl_rd_data[13]}, 32'h3);
        repeat (4) @(negedge clk);
        chk("R6 held", {31'h0, flush_req_o}, 32'h1);
        flush_done_i = 1'b1;
        @(negedge clk);
        flush_done_i = 1'b0;
        chk("R6 done clears", {30'h0, flush_req_o, ctl_rd_data[13]}, 32'h0);
        wr(16'h2000, 16'h2000);
        wr(16'h2000, 16'h0000);
        chk("R6 write0 clears", {31'h0, flush_req_o}, 32'h0);

        // R7 wake
        wr(16'h1000, 16'h1000);
        chk("R7 pulse", {30'h0, wake_o, ctl_rd_data[12]}, 32'h3);
        @(negedge clk);
        chk("R7 self clear", {30'h0, wake_o, ctl_rd_data[12]}, 32'h0);

        // R8 stop handshake
        use_resp = 1'b1;
        wr(16'hA000, 16'hA000);
        repeat (4) @(negedge clk);
        chk("R8 engine active", {31'h0, ctl_rd_data[10]}, 32'h1);
        wr(16'hA000, 16'h0000);
        chk("R8 run/flush off", {30'h0, run_o, flush_req_o}, 32'h0);
        begin
            int waited = 0;
            while ((ctl_rd_data[15:0] & 16'h2400) != 0 && waited < 10) begin
                @(negedge clk);
                waited++;
            end
            chk("R8 idle reached", {16'h0, ctl_rd_data[15:0] & 16'h2400}, 32'h0);
        end
        use_resp = 1'b0;

        // R9 reset write
        wr(16'hF000, 16'hE000);
        @(negedge clk); eng_dead_i = 1'b1;
        @(negedge clk); eng_dead_i = 1'b0;
        chk("R9 preset", {27'h0, ctl_rd_data[15:11]}, 32'h1D);
        wr(16'hFC00, 16'h0000);
        chk("R9 cleared", {27'h0, ctl_rd_data[15:11]}, 32'h0);
        chk("R9 pins", {28'h0, run_o, pause_o, flush_req_o, wake_o}, 32'h0);

        finish_run();
    end
endmodule